// File: doc/BRIEF.md
# Synchronous Slave FIFO Port for a USB 3.0 Controller

This block is the bus-side engine for an external USB 3.0 controller that exposes a synchronous slave FIFO. It runs at a nominal 100 MHz and returns an inverted copy of its clock to the controller as the interface clock. One 32-bit bidirectional data bus carries words in both directions. The block selects the controller FIFO with a 2-bit address, sets the bus direction with a direction output, and moves words with two active-low strobes. Two pairs of status flags gate the transfers.

In receive mode the block pulls words from the controller's inbound FIFO. Each word goes into a local buffer at the next free address and a length register counts it. In transmit mode, started by a one-cycle request with a word count, the block reads words from a local buffer in address order and writes them to the outbound FIFO. The byte order of every word is reversed between the bus and the buffer, in both directions. A transfer in either direction pauses in the same cycle that either flag of its pair falls. It continues from the same buffer address once both flags are high again.

Top module: `usb_fifo_port`

## Requirements
- R1: `ifclk_o` is always the logical inverse of `clk_i`.
- R2: After reset `bus_in_o`=1, `fifo_sel_o`=2'd1, `rd_n_o`=1, `wr_n_o`=1, `rx_len_o`=0, `tx_busy_o`=0 and `tx_done_o`=0.
- R3: In receive mode, a word is read in any cycle with both `rd_rdy_a_i` and `rd_rdy_b_i` high, `rx_clear_i` low and `rx_len_o` < DEPTH. In that cycle `rd_n_o` is low, `rxb_we_o` is high and `rxb_addr_o` equals `rx_len_o`. The word on `data_io` at the closing rising edge is the one stored, and `rx_len_o` then rises by one.
- R4: Byte k of a bus word (bits 8k+7:8k) is byte 3-k of the buffer word, in both directions. Bus 0x03020100 corresponds to buffer 0x00010203.
- R5: A strobe stays high in every cycle in which either flag of its pair is low. A paused transfer resumes at the same buffer address, with no word lost or repeated.
- R6: When `rx_len_o` equals DEPTH, no further reads take place. Asserting `rx_clear_i` for one cycle blocks any read in that cycle and sets `rx_len_o` to 0 on the next.
- R7: `tx_start_i` in receive mode with a nonzero `tx_len_i` starts a transmit session on the next cycle: `tx_busy_o`=1, `bus_in_o`=0, `fifo_sel_o`=2'd0. The session writes buffer words 0 to N-1 in order, where N is `tx_len_i` capped at DEPTH. A word is written in each cycle with both `wr_rdy_a_i` and `wr_rdy_b_i` high; in that cycle `wr_n_o` is low and `data_io` carries the byte-reversed `txb_rdata_i`.
- R8: In the cycle after the last write, `tx_busy_o` is 0, `tx_done_o` is high for exactly that one cycle, and the block is back in receive mode (`bus_in_o`=1, `fifo_sel_o`=2'd1).
- R9: `tx_start_i` has no effect while a session is active or when `tx_len_i` is 0.
- R10: No read takes place during a transmit session. The two strobes are never low together. The block drives `data_io` only while `bus_in_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock, nominally 100 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ifclk_o | output | 1 | Inverted clock sent to the controller |
| wr_rdy_a_i | input | 1 | Outbound-ready flag, first of pair |
| wr_rdy_b_i | input | 1 | Outbound-ready flag, second of pair |
| rd_rdy_a_i | input | 1 | Inbound-data flag, first of pair |
| rd_rdy_b_i | input | 1 | Inbound-data flag, second of pair |
| bus_in_o | output | 1 | 1: controller drives the bus; 0: block drives it |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| fifo_sel_o | output | 2 | Controller FIFO select: 0 outbound, 1 inbound |
| data_io | inout | DATA_W | Shared data bus |
| rxb_we_o | output | 1 | Receive-buffer write enable |
| rxb_addr_o | output | AW | Receive-buffer write address |
| rxb_wdata_o | output | DATA_W | Receive-buffer write data |
| rx_len_o | output | LEN_W | Count of words received |
| rx_clear_i | input | 1 | Pulse that empties the receive count |
| txb_addr_o | output | AW | Transmit-buffer read address |
| txb_rdata_i | input | DATA_W | Transmit-buffer read data, same-cycle |
| tx_len_i | input | LEN_W | Words to send in the session |
| tx_start_i | input | 1 | Session start request |
| tx_busy_o | output | 1 | Transmit session active |
| tx_done_o | output | 1 | One-cycle end-of-session pulse |

## Verification
The assertions assume the following about the inputs:
- The controller drives the bus only while `bus_in_o` is high and the inbound FIFO is selected.
- The transmit buffer returns data for `txb_addr_o` within the same cycle.
- The flags change only away from the rising edge.

The bench controller model meets these conditions. It drives `data_io` only under that condition, changes the flags and controls only on the falling edge, and serves buffer data combinationally from its own array. The random part toggles each flag on its own, so pauses land on any word position in both directions. It also issues a second start request partway through a session.

// File: rtl/usb_fifo_pkg.sv
package usb_fifo_pkg;
  typedef enum logic {
    MODE_RX = 1'b0,
    MODE_TX = 1'b1
  } bus_mode_e;

  localparam logic [1:0] SEL_OUTBOUND = 2'd0;
  localparam logic [1:0] SEL_INBOUND  = 2'd1;
endpackage

// File: rtl/usb_byte_rev.sv
module usb_byte_rev #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int NBYTES = DATA_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign word_o[8*b +: 8] = word_i[8*(NBYTES-1-b) +: 8];
  end
endmodule

// File: rtl/usb_dir_ctrl.sv
module usb_dir_ctrl
  import usb_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_start_i,
  input  logic [LEN_W-1:0] tx_len_i,
  input  logic             last_wr_i,
  output bus_mode_e        mode_o,
  output logic [LEN_W-1:0] len_o,
  output logic             start_o,
  output logic             done_o,
  output logic             run_o
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DEPTH);

  bus_mode_e        mode_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q, run_q, accept;

  assign accept = run_q && (mode_q == MODE_RX) && tx_start_i && (tx_len_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RX;
      len_q  <= '0;
      done_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      done_q <= (mode_q == MODE_TX) && last_wr_i;
      if (accept) begin
        mode_q <= MODE_TX;
        len_q  <= (tx_len_i > MAX_LEN) ? MAX_LEN : tx_len_i;
      end else if ((mode_q == MODE_TX) && last_wr_i) begin
        mode_q <= MODE_RX;
      end
    end
  end

  assign mode_o  = mode_q;
  assign len_o   = len_q;
  assign start_o = accept;
  assign done_o  = done_q;
  assign run_o   = run_q;

  // R9: session length frozen while transmitting
  a_r9_len_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TX && !last_wr_i) |=> $stable(len_q) && mode_q == MODE_TX)
    else $error("a_r9_len_frozen");
  // R8: end pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q) else $error("a_r8_done_single");
  a_r7_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TX) |-> (len_q != '0 && len_q <= MAX_LEN))
    else $error("a_r7_len_nonzero");
endmodule

// File: rtl/usb_rx_path.sv
module usb_rx_path
  import usb_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int AW     = $clog2(DEPTH),
  parameter int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  bus_mode_e         mode_i,
  input  logic              rdy_a_i,
  input  logic              rdy_b_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] bus_word_i,
  output logic              rd_n_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LEN_W-1:0]  count_o
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

  logic [LEN_W-1:0] count_q;
  logic             rd_go;

  assign rd_go = run_i && (mode_i == MODE_RX) && rdy_a_i && rdy_b_i &&
                 !clear_i && (count_q != FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (clear_i) count_q <= '0;
    else if (rd_go)   count_q <= count_q + 1'b1;
  end

  usb_byte_rev #(.DATA_W(DATA_W)) u_rev (
    .word_i (bus_word_i),
    .word_o (wdata_o)
  );

  assign rd_n_o  = !rd_go;
  assign we_o    = rd_go;
  assign addr_o  = count_q[AW-1:0];
  assign count_o = count_q;

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |=> count_o == $past(count_o) + 1'b1) else $error("a_r3_count_step");
  a_r6_count_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL) else $error("a_r6_count_limit");
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0) else $error("a_r6_clear");
  a_r5_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_n_o && !clear_i) |=> $stable(count_o)) else $error("a_r5_rx_hold");
endmodule

// File: rtl/usb_tx_path.sv
module usb_tx_path
  import usb_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int AW     = $clog2(DEPTH),
  parameter int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  bus_mode_e         mode_i,
  input  logic              rdy_a_i,
  input  logic              rdy_b_i,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              wr_n_o,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] bus_word_o,
  output logic              last_o
);
  logic [LEN_W-1:0] ptr_q;
  logic             wr_go, at_end;

  assign wr_go  = run_i && (mode_i == MODE_TX) && rdy_a_i && rdy_b_i;
  assign at_end = (ptr_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (start_i) ptr_q <= '0;
    else if (wr_go)   ptr_q <= at_end ? '0 : ptr_q + 1'b1;
  end

  usb_byte_rev #(.DATA_W(DATA_W)) u_rev (
    .word_i (rdata_i),
    .word_o (bus_word_o)
  );

  assign wr_n_o = !wr_go;
  assign addr_o = ptr_q[AW-1:0];
  assign last_o = wr_go && at_end;

  // R5: pointer holds across a pause
  a_r5_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TX && wr_n_o) |=> $stable(ptr_q)) else $error("a_r5_tx_hold");
  a_r7_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TX) |-> ptr_q < len_i) else $error("a_r7_ptr_range");
  a_r7_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_o && !last_o) |=> ptr_q == $past(ptr_q) + 1'b1) else $error("a_r7_ptr_step");
endmodule

// File: rtl/usb_fifo_port.sv
module usb_fifo_port
  import usb_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int AW     = $clog2(DEPTH),
  parameter int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              ifclk_o,
  input  logic              wr_rdy_a_i,
  input  logic              wr_rdy_b_i,
  input  logic              rd_rdy_a_i,
  input  logic              rd_rdy_b_i,
  output logic              bus_in_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [1:0]        fifo_sel_o,
  inout  wire  [DATA_W-1:0] data_io,
  output logic              rxb_we_o,
  output logic [AW-1:0]     rxb_addr_o,
  output logic [DATA_W-1:0] rxb_wdata_o,
  output logic [LEN_W-1:0]  rx_len_o,
  input  logic              rx_clear_i,
  output logic [AW-1:0]     txb_addr_o,
  input  logic [DATA_W-1:0] txb_rdata_i,
  input  logic [LEN_W-1:0]  tx_len_i,
  input  logic              tx_start_i,
  output logic              tx_busy_o,
  output logic              tx_done_o
);
  bus_mode_e         mode;
  logic [LEN_W-1:0]  len;
  logic              start, run, last_wr;
  logic [DATA_W-1:0] tx_word;

  assign ifclk_o = ~clk_i;

  usb_dir_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .tx_start_i,
    .tx_len_i,
    .last_wr_i (last_wr),
    .mode_o    (mode),
    .len_o     (len),
    .start_o   (start),
    .done_o    (tx_done_o),
    .run_o     (run)
  );

  usb_rx_path #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .LEN_W(LEN_W)) u_rx (
    .clk_i, .rst_ni,
    .run_i      (run),
    .mode_i     (mode),
    .rdy_a_i    (rd_rdy_a_i),
    .rdy_b_i    (rd_rdy_b_i),
    .clear_i    (rx_clear_i),
    .bus_word_i (data_io),
    .rd_n_o,
    .we_o       (rxb_we_o),
    .addr_o     (rxb_addr_o),
    .wdata_o    (rxb_wdata_o),
    .count_o    (rx_len_o)
  );

  usb_tx_path #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .LEN_W(LEN_W)) u_tx (
    .clk_i, .rst_ni,
    .run_i      (run),
    .mode_i     (mode),
    .rdy_a_i    (wr_rdy_a_i),
    .rdy_b_i    (wr_rdy_b_i),
    .start_i    (start),
    .len_i      (len),
    .rdata_i    (txb_rdata_i),
    .wr_n_o,
    .addr_o     (txb_addr_o),
    .bus_word_o (tx_word),
    .last_o     (last_wr)
  );

  assign bus_in_o   = (mode == MODE_RX);
  assign fifo_sel_o = (mode == MODE_RX) ? SEL_INBOUND : SEL_OUTBOUND;
  assign tx_busy_o  = (mode == MODE_TX);
  assign data_io    = bus_in_o ? {DATA_W{1'bz}} : tx_word;

  a_r10_no_rd_in_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_o |-> rd_n_o) else $error("a_r10_no_rd_in_tx");
  a_r10_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o)) else $error("a_r10_strobe_excl");
  a_r7_wr_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> (!bus_in_o && fifo_sel_o == SEL_OUTBOUND)) else $error("a_r7_wr_dir");
  a_r3_rd_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> (bus_in_o && fifo_sel_o == SEL_INBOUND)) else $error("a_r3_rd_dir");
  a_r8_done_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> (bus_in_o && !tx_busy_o)) else $error("a_r8_done_rx");
endmodule

// File: tb/sim_usb_fifo_port.sv
module sim_usb_fifo_port;
  localparam int DW = 32, DEPTH = 8, AW = 3, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wa = 0, wb = 0, ra = 0, rb = 0, clr = 0, start = 0;
  logic [LW-1:0] tlen = '0;
  wire  [DW-1:0] data_io;
  logic ifclk, bus_in, rd_n, wr_n, we, busy, done;
  logic [1:0] sel;
  logic [AW-1:0] waddr, taddr;
  logic [DW-1:0] wdata;
  logic [LW-1:0] rlen;

  logic [DW-1:0] host_in [64];
  logic [DW-1:0] host_out[32];
  logic [DW-1:0] rx_mem  [DEPTH];
  logic [DW-1:0] tx_mem  [DEPTH];
  int hi = 0, ho = 0, done_cnt = 0, viol = 0;
  int checks = 0, fails = 0;
  int unsigned seed_v;

  always #10 clk = ~clk;

  assign data_io = (bus_in && sel == 2'd1) ? host_in[hi & 63] : {DW{1'bz}};

  usb_fifo_port #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ifclk_o(ifclk),
    .wr_rdy_a_i(wa), .wr_rdy_b_i(wb), .rd_rdy_a_i(ra), .rd_rdy_b_i(rb),
    .bus_in_o(bus_in), .rd_n_o(rd_n), .wr_n_o(wr_n), .fifo_sel_o(sel),
    .data_io(data_io), .rxb_we_o(we), .rxb_addr_o(waddr), .rxb_wdata_o(wdata),
    .rx_len_o(rlen), .rx_clear_i(clr), .txb_addr_o(taddr),
    .txb_rdata_i(tx_mem[taddr]), .tx_len_i(tlen), .tx_start_i(start),
    .tx_busy_o(busy), .tx_done_o(done)
  );

  // controller and buffer models
  always @(posedge clk) begin
    if (rst_n) begin
      if (!rd_n) hi <= hi + 1;
      if (!wr_n && ho < 32) begin host_out[ho] <= data_io; ho <= ho + 1; end
      if (we) rx_mem[waddr] <= wdata;
      if (done) done_cnt <= done_cnt + 1;
      if (!rd_n && !(ra && rb)) viol <= viol + 1;
      if (!wr_n && !(wa && wb)) viol <= viol + 1;
      if (!rd_n && !wr_n) viol <= viol + 1;
      if (!rd_n && busy) viol <= viol + 1;
    end
  end

  function automatic logic [DW-1:0] rev(input logic [DW-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    int ho0, dc0, n;
    seed_v = $urandom(32'd4242);
    for (int i = 0; i < 64; i++) host_in[i] = $urandom;
    host_in[0] = 32'h03020100;
    for (int i = 0; i < DEPTH; i++) tx_mem[i] = $urandom;
    tx_mem[0] = 32'h00010203;

    // R2 reset state
    repeat (3) @(negedge clk);
    chk(bus_in == 1 && sel == 2'd1, "R2 dir", {bus_in, 29'd0, sel}, {1'b1, 29'd0, 2'd1});
    chk(rd_n && wr_n && rlen == 0 && !busy && !done, "R2 idle", {rd_n, wr_n, busy, done, 24'd0, rlen}, 32'hc0000000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ifclk == 1'b1, "R1 low phase", ifclk, 1);
    @(posedge clk); #1;
    chk(ifclk == 1'b0, "R1 high phase", ifclk, 0);

    // R3/R4 directed single receive
    @(negedge clk); ra = 1; rb = 1; #1;
    chk(!rd_n && we && waddr == 0, "R3 strobe", {rd_n, we, 27'd0, waddr}, 32'h40000000);
    @(negedge clk); ra = 0; rb = 0;
    chk(rlen == 1, "R3 count", rlen, 1);
    chk(rx_mem[0] == 32'h00010203, "R4 rx order", rx_mem[0], 32'h00010203);

    // R5 one flag low blocks at once
    ra = 1; #1;
    chk(rd_n == 1, "R5 rx pause", rd_n, 1);
    @(negedge clk); ra = 0;
    chk(rlen == 1, "R5 rx hold", rlen, 1);

    // R3/R5/R6 random receive until full
    for (int c = 0; c < 80; c++) begin
      @(negedge clk); ra = ($urandom % 4) != 0; rb = ($urandom % 4) != 0;
    end
    @(negedge clk); ra = 0; rb = 0;
    chk(rlen == DEPTH, "R6 full count", rlen, DEPTH);
    chk(hi == DEPTH, "R6 no read when full", hi, DEPTH);
    n = 0;
    for (int i = 0; i < DEPTH; i++) if (rx_mem[i] != rev(host_in[i])) n++;
    chk(n == 0, "R3 random words", n, 0);

    // R6 clear blocks read in its cycle
    ra = 1; rb = 1; clr = 1; #1;
    chk(rd_n == 1, "R6 clear blocks", rd_n, 1);
    @(negedge clk); clr = 0;
    chk(rlen == 0, "R6 clear", rlen, 0);
    @(negedge clk); ra = 0; rb = 0;
    chk(rlen == 1 && rx_mem[0] == rev(host_in[DEPTH]), "R6 after clear", rx_mem[0], rev(host_in[DEPTH]));

    // R7/R8/R10 directed single transmit
    ho0 = ho; dc0 = done_cnt;
    tlen = 1; start = 1; wa = 1; wb = 1; ra = 1; rb = 1;
    @(negedge clk); start = 0; #1;
    chk(busy && !bus_in && sel == 2'd0, "R7 tx mode", {busy, bus_in, 28'd0, sel}, 32'h80000000);
    chk(!wr_n && data_io == 32'h03020100, "R4 tx order", data_io, 32'h03020100);
    chk(rd_n == 1, "R10 no read in tx", rd_n, 1);
    @(negedge clk); ra = 0; rb = 0;
    chk(!busy && done && bus_in && sel == 2'd1, "R8 end", {busy, done, bus_in, 27'd0, sel}, 32'h60000001);
    @(negedge clk);
    chk(!done && done_cnt == dc0 + 1 && ho == ho0 + 1, "R8 single pulse", done_cnt - dc0, 1);

    // R7/R9/R5 random transmit, length capped, restart ignored
    ho0 = ho; dc0 = done_cnt;
    tlen = 4'd12; start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 400 && busy; c++) begin
      wa = ($urandom % 3) != 0; wb = ($urandom % 3) != 0;
      start = (c == 3); tlen = 4'd3;
      @(negedge clk);
    end
    start = 0; wa = 0; wb = 0;
    @(negedge clk);
    chk(ho - ho0 == DEPTH, "R7 capped length", ho - ho0, DEPTH);
    n = 0;
    for (int i = 0; i < DEPTH; i++) if (host_out[ho0 + i] != rev(tx_mem[i])) n++;
    chk(n == 0, "R7 random words", n, 0);
    chk(done_cnt == dc0 + 1, "R9 restart ignored", done_cnt - dc0, 1);

    // R9 zero length ignored
    tlen = 0; start = 1;
    @(negedge clk); start = 0;
    chk(!busy && bus_in, "R9 zero length", busy, 0);

    chk(viol == 0, "R5 R10 strobe rules", viol, 0);
    summary();
    $finish;
  end
endmodule